// File: doc/BRIEF.md
# SPI Serial EEPROM Write-Path Slave

This block is the slave-side command engine of a serial EEPROM reached over SPI, reduced to the write path and status polling. A host lowers chip select, shifts in an 8-bit command and, for a write, a 16-bit address followed by data bytes. The data bytes collect in a one-page staging buffer. When the host raises chip select, a timed internal programming cycle copies the staged bytes into a small backing array. While that cycle runs, the block ignores every command except the status read.

The SPI pins are sampled by a faster system clock, so SCK must stay at each level for at least four system clocks. The SPI data path has no back-pressure: the host sets the pace, and every complete byte is consumed in the cycle it arrives. The SO output comes with an output-enable. The pad driver leaves the line floating whenever `so_oe` is low. A plain combinational lookup port on the backing array lets the surrounding logic read the stored bytes.

Top module: `spi_ee_wr`

## Requirements
- R1: After reset the status byte reads 00h. Command 06h sets the write-enable latch. The status command 05h returns a byte with the latch in bit 1 and the busy flag in bit 0, so a status read right after 06h gives 02h.
- R2: Command 02h is followed by a 16-bit address, high byte first, and then data. Address bits [MEM_AW-1:0] pick the byte. Bit 15 and every other bit above MEM_AW-1 are ignored.
- R3: A 02h command sent while the write-enable latch is clear is ignored, and the array is left unchanged.
- R4: A programming cycle starts only on the rising edge of chip select, and only after at least one complete data byte of an accepted write. Raising chip select earlier in the sequence starts nothing.
- R5: The programming cycle lasts WCYC system clocks. During it, the status command returns FFh.
- R6: During the programming cycle every command other than 05h is ignored, including a complete write sequence.
- R7: The write-enable latch clears when the programming cycle ends, so the status byte afterwards reads 00h.
- R8: After each data byte the low PAGE_AW address bits increment and the page bits stay fixed. Bytes past the page end wrap to the start of the same page and overwrite bytes already staged there.
- R9: Only bytes staged by the write are committed. Other bytes of the page keep their old values, and the array changes only during the programming cycle.
- R10: SPI modes (0,0) and (1,1) both work. SI is sampled on rising SCK, and SO changes on falling SCK, MSB first.
- R11: `so_oe` is low whenever chip select is high, and low while no status byte is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI data from the host |
| so | output | 1 | SPI data to the host |
| so_oe | output | 1 | Output enable for the SO pad driver |
| rd_addr | input | MEM_AW | Lookup address into the backing array |
| rd_data | output | 8 | Byte stored at rd_addr |

## Verification
The checker watches these rules on every cycle: the output enable stays tied to an active chip select, a status bit is all ones during a busy window, programming begins only at a chip-select rising edge, the latch is clear when busy drops, the page stays fixed while data is loading, and the array is written only while busy. The wrap-around overwrite, the untouched neighbours within a page, the don't-care address bit, the commands dropped during busy or without the latch, and operation in both clock polarities depend on the contents of the array after whole SPI transactions. Only the bench scenarios, which read the array back, can show them.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_WEL_BIT  = 1;
  typedef enum logic [2:0] {
    E_IDLE, E_OPC, E_AHI, E_ALO, E_DATA, E_STAT, E_SKIP
  } eng_st_t;
endpackage

// File: rtl/spi_ee_front.sv
// Oversampled SPI pin front end: synchronisers, edge pulses, byte
// deserialiser and the status shifter.
module spi_ee_front #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         si,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_en,
  output logic         cs_act,
  output logic         cs_fall,
  output logic         cs_rise,
  output logic         byte_vld,
  output logic [W-1:0] byte_q,
  output logic         so_bit,
  output logic         oe_q
);
  localparam int CW = $clog2(W);

  logic [2:0]    sck_s, cs_s;
  logic [1:0]    si_s;
  logic [CW-1:0] bcnt;
  logic [W-2:0]  rx_sr;
  logic [W-1:0]  tx_sr;
  logic          sck_r, sck_f;

  assign sck_r   = sck_s[1] & ~sck_s[2];
  assign sck_f   = ~sck_s[1] & sck_s[2];
  assign cs_act  = ~cs_s[1];
  assign cs_fall = cs_s[2] & ~cs_s[1];
  assign cs_rise = ~cs_s[2] & cs_s[1];
  assign so_bit  = tx_sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s    <= '0;
      cs_s     <= '1;
      si_s     <= '0;
      bcnt     <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      oe_q     <= 1'b0;
    end else begin
      sck_s    <= {sck_s[1:0], sck};
      cs_s     <= {cs_s[1:0], cs_n};
      si_s     <= {si_s[0], si};
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bcnt <= '0;
        oe_q <= 1'b0;
      end else begin
        if (sck_r) begin
          rx_sr <= {rx_sr[W-3:0], si_s[1]};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == CW'(W - 1)) begin
            byte_vld <= 1'b1;
            byte_q   <= {rx_sr, si_s[1]};
          end
        end
        if (sck_f) begin
          if (bcnt == '0) begin
            tx_sr <= tx_byte;
            oe_q  <= tx_en;
          end else begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_ee_engine.sv
// Command decoder, page staging buffer and timed programming cycle.
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int MEM_AW  = 9,
  parameter int PAGE_AW = 6,
  parameter int WCYC    = 400
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_fall,
  input  logic                      cs_rise,
  input  logic                      byte_vld,
  input  logic [7:0]                byte_q,
  output logic [7:0]                tx_byte,
  output logic                      tx_en,
  output logic                      busy,
  output logic                      wel,
  output logic                      in_data,
  output logic [MEM_AW-PAGE_AW-1:0] pg,
  output logic                      mem_we,
  output logic [MEM_AW-1:0]         mem_wa,
  output logic [7:0]                mem_wd
);
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int HI_W  = MEM_AW - 8;
  localparam int CNT_W = $clog2(WCYC + 1);

  eng_st_t            st;
  logic [HI_W-1:0]    a_hi;
  logic [PAGE_AW-1:0] off;
  logic [CNT_W-1:0]   cnt;
  logic               got;
  logic [PAGE-1:0]    pvld;
  logic [7:0]         pbuf [PAGE];
  logic [MEM_AW-1:0]  a_full;
  logic [PAGE_AW-1:0] cidx;
  logic [7:0]         stat_idle;

  assign a_full  = {a_hi, byte_q};
  assign cidx    = cnt[PAGE_AW-1:0];
  assign tx_en   = (st == E_STAT);
  assign in_data = (st == E_DATA);

  always_comb begin
    stat_idle = '0;
    stat_idle[STAT_WEL_BIT]  = wel;
    stat_idle[STAT_BUSY_BIT] = 1'b0;
    tx_byte = busy ? 8'hFF : stat_idle;
  end

  assign mem_we = busy && (cnt < CNT_W'(PAGE)) && pvld[cidx];
  assign mem_wa = {pg, cidx};
  assign mem_wd = pbuf[cidx];

  always_ff @(posedge clk) begin
    if (byte_vld && st == E_DATA) pbuf[off] <= byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= E_IDLE;
      a_hi <= '0;
      off  <= '0;
      pg   <= '0;
      cnt  <= '0;
      got  <= 1'b0;
      pvld <= '0;
      busy <= 1'b0;
      wel  <= 1'b0;
    end else begin
      if (busy) begin
        if (cnt == CNT_W'(WCYC - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          pvld <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (cs_fall) begin
        st <= E_OPC;
      end else if (cs_rise) begin
        if (st == E_DATA && got) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
        st  <= E_IDLE;
        got <= 1'b0;
      end else if (byte_vld) begin
        case (st)
          E_OPC: begin
            if (busy) begin
              st <= (byte_q == OPC_RDSR) ? E_STAT : E_SKIP;
            end else begin
              case (byte_q)
                OPC_WREN: begin
                  wel <= 1'b1;
                  st  <= E_SKIP;
                end
                OPC_WRITE: begin
                  if (wel) begin
                    st   <= E_AHI;
                    pvld <= '0;
                  end else begin
                    st <= E_SKIP;
                  end
                end
                OPC_RDSR: st <= E_STAT;
                default:  st <= E_SKIP;
              endcase
            end
          end
          E_AHI: begin
            a_hi <= byte_q[HI_W-1:0];
            st   <= E_ALO;
          end
          E_ALO: begin
            pg  <= a_full[MEM_AW-1:PAGE_AW];
            off <= a_full[PAGE_AW-1:0];
            st  <= E_DATA;
          end
          E_DATA: begin
            pvld[off] <= 1'b1;
            off       <= off + 1'b1;
            got       <= 1'b1;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ee_mem.sv
// Backing byte array: one write port, one combinational lookup port.
module spi_ee_mem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd = mem[ra];
endmodule

// File: rtl/spi_ee_wr.sv
// Top: SPI EEPROM write-path slave. MEM_AW must lie between 9 and 15,
// and WCYC must be at least 1 << PAGE_AW.
module spi_ee_wr #(
  parameter int MEM_AW  = 9,
  parameter int PAGE_AW = 6,
  parameter int WCYC    = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int PW = MEM_AW - PAGE_AW;

  logic          cs_act, cs_fall, cs_rise, byte_vld, so_bit, oe_q;
  logic [7:0]    byte_q, tx_byte, mem_wd;
  logic          tx_en, busy, wel, in_data, mem_we;
  logic [PW-1:0] pg;
  logic [MEM_AW-1:0] mem_wa;

  spi_ee_front #(.W(8)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .tx_byte(tx_byte), .tx_en(tx_en),
    .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_vld(byte_vld), .byte_q(byte_q), .so_bit(so_bit), .oe_q(oe_q)
  );

  spi_ee_engine #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WCYC(WCYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_vld(byte_vld), .byte_q(byte_q),
    .tx_byte(tx_byte), .tx_en(tx_en), .busy(busy), .wel(wel),
    .in_data(in_data), .pg(pg),
    .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd)
  );

  spi_ee_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .ra(rd_addr), .rd(rd_data)
  );

  assign so_oe = oe_q & cs_act;
  assign so    = so_oe ? so_bit : 1'b0;
endmodule

// File: rtl/spi_ee_wr_chk.sv
module spi_ee_wr_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          cs_rise,
  input logic          busy,
  input logic          wel,
  input logic          in_data,
  input logic          so,
  input logic          so_oe,
  input logic          mem_we,
  input logic [PW-1:0] pg
);
  assert_oe_needs_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> cs_act);
  assert_busy_reads_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && busy) |-> so);
  assert_start_at_cs_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  assert_latch_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_page_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data)) |-> $stable(pg));
  assert_write_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

bind spi_ee_wr spi_ee_wr_chk #(.PW(MEM_AW - PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
  .busy(busy), .wel(wel), .in_data(in_data), .so(so), .so_oe(so_oe),
  .mem_we(mem_we), .pg(pg)
);

// File: tb/test_spi_ee_wr.sv
`timescale 1ns/1ps
module test_spi_ee_wr;
  localparam int AW   = 9;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic cpol = 1'b0;
  logic oe_last = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_ee_wr #(.MEM_AW(AW), .PAGE_AW(6), .WCYC(1200)) i_spi_ee_wr (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // mode bit (1 = SCK idles high), 16-bit address, data byte
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0005, 8'hA5},
    {1'b0, 16'h8011, 8'h5A},
    {1'b1, 16'h0020, 8'hC3},
    {1'b1, 16'h81C7, 8'h3C},
    {1'b0, 16'h7E3F, 8'h81},
    {1'b1, 16'h0000, 8'hFE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    if (cpol) sck = 1'b0;
    si = b;
    #HALF;
    r = so;
    oe_last = so_oe;
    sck = 1'b1;
    #HALF;
    if (!cpol) sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic cs_lo();
    sck = cpol;
    #HALF; cs_n = 1'b0; #HALF;
  endtask

  task automatic cs_hi();
    #HALF; cs_n = 1'b1; #(3*HALF);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); xbyte(8'h06, d); cs_hi();
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] seed);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) xbyte(seed + 8'(k), d);
    cs_hi();
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] s = 8'hFF;
    for (int i = 0; i < 40; i++) begin
      rd_status(s);
      if (!s[0]) break;
    end
    chk(tag, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] v);
    rd_addr = a[AW-1:0];
    #1;
    v = rd_data;
  endtask

  initial begin
    #900us;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v;
    #52 rst_n = 1'b1;
    #50;
    // reset state
    chk("R11 so_oe after reset", {31'd0, so_oe}, 32'd0);
    rd_status(s);
    chk("R1 status after reset", {24'd0, s}, 32'h00);
    chk("R10 SO enabled while status shifts (mode 0)", {31'd0, oe_last}, 32'd1);
    chk("R11 so_oe after deselect", {31'd0, so_oe}, 32'd0);

    // R3: write without the latch
    write_seq(16'h0100, 1, 8'h3C);
    rd_status(s);
    chk("R3 no cycle without latch", {24'd0, s}, 32'h00);
    peek(16'h0100, v);
    chk("R3 array unchanged", {24'd0, v}, 32'h00);

    // table of single-byte writes in both modes
    foreach (VEC[i]) begin
      cpol = VEC[i][24];
      wren();
      if (i == 0) begin
        rd_status(s);
        chk("R1 status after write enable", {24'd0, s}, 32'h02);
      end
      write_seq(VEC[i][23:8], 1, VEC[i][7:0]);
      wait_ready("R5 cycle completes");
      peek(VEC[i][23:8], v);
      chk("R2 R10 stored byte", {24'd0, v}, {24'd0, VEC[i][7:0]});
      rd_status(s);
      chk("R7 latch cleared after cycle", {24'd0, s}, 32'h00);
    end

    // R5 R6: busy window
    cpol = 1'b0;
    wren();
    write_seq(16'h0140, 1, 8'h77);
    rd_status(s);
    chk("R5 status while busy", {24'd0, s}, 32'hFF);
    write_seq(16'h0150, 1, 8'h99);
    wait_ready("R5 cycle completes");
    peek(16'h0150, v);
    chk("R6 write during busy ignored", {24'd0, v}, 32'h00);
    peek(16'h0140, v);
    chk("R4 committed after cs rise", {24'd0, v}, 32'h77);

    // R4: deselect inside the address phase
    wren();
    cs_lo(); xbyte(8'h02, v); xbyte(8'h01, v); xbyte(8'h80, v); cs_hi();
    rd_status(s);
    chk("R4 no cycle after aborted address", {24'd0, s}, 32'h02);
    peek(16'h0180, v);
    chk("R4 array untouched by abort", {24'd0, v}, 32'h00);

    // R8: wrap inside page 2 (base 0x080), start at offset 62, 66 bytes
    write_seq(16'h00BE, 66, 8'h10);
    wait_ready("R8 cycle completes");
    peek(16'h00BE, v); chk("R8 offset 62 overwritten", {24'd0, v}, 32'h50);
    peek(16'h00BF, v); chk("R8 offset 63 overwritten", {24'd0, v}, 32'h51);
    peek(16'h0080, v); chk("R8 wrap to offset 0", {24'd0, v}, 32'h12);
    peek(16'h00BD, v); chk("R8 offset 61", {24'd0, v}, 32'h4F);
    peek(16'h00C0, v); chk("R8 next page untouched", {24'd0, v}, 32'h00);

    // R9: partial page in mode (1,1)
    cpol = 1'b1;
    wren();
    write_seq(16'h00CA, 1, 8'hAA);
    wait_ready("R9 cycle completes");
    wren();
    write_seq(16'h00C5, 2, 8'h20);
    wait_ready("R9 cycle completes");
    peek(16'h00C5, v); chk("R9 first staged byte", {24'd0, v}, 32'h20);
    peek(16'h00C6, v); chk("R8 increment", {24'd0, v}, 32'h21);
    peek(16'h00CA, v); chk("R9 unstaged byte kept", {24'd0, v}, 32'hAA);
    peek(16'h00C4, v); chk("R9 byte before start kept", {24'd0, v}, 32'h00);
    rd_status(s);
    chk("R10 status in mode (1,1)", {24'd0, s}, 32'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule